// File: doc/BRIEF.md
# Parallel Converter Read Sequencer

This block sits on the host side of a successive-approximation converter that has a parallel output bus. It starts a conversion by driving the converter's convert and select lines in a fixed order. It then waits for the converter's ready line to fall and rise again, reads the 16-bit result and presents it on a one-cycle valid/data port. The result is read either as one 16-bit word or as two bytes over an 8-bit bus; in the byte case a byte-select line picks the half being read.

A conversion is requested by a one-cycle start strobe or by an internal periodic timer. A request that arrives while a conversion is running, or before the minimum spacing since the last conversion has elapsed, is held and served at the first cycle it is allowed. Every interval is a count of system clock cycles taken from a parameter. If ready does not come back within a set limit, a watchdog raises a timeout strobe and the block returns to idle.

Top module: `adc_read_seq`

## Requirements
- R1: While reset is held, both converter control lines (`adc_sel_n_o`, `adc_conv_n_o`) are high, `adc_lo_byte_o` is 0, and `res_valid_o` and `timeout_o` are 0.
- R2: The convert pulse holds `adc_sel_n_o` and `adc_conv_n_o` both low for exactly PULSE_CYC cycles.
- R3: Before each convert pulse, `adc_conv_n_o` is low while `adc_sel_n_o` is high for exactly SETUP_CYC cycles, so the select line falling is what triggers the conversion.
- R4: Two convert pulses never start fewer than SPACING_CYC cycles apart.
- R5: The bus is enabled (`adc_sel_n_o` low with `adc_conv_n_o` high) only while `adc_ready_i` is high, and at least one control line is high whenever `adc_ready_i` rises.
- R6: In byte mode (BYTE_MODE=1) the bus is read twice. The first read has `adc_lo_byte_o`=0 and gives result bits 15:8. The second has `adc_lo_byte_o`=1 and gives bits 7:0. Each read samples the bus after the bus has been enabled and the byte select has been stable for ACCESS_CYC cycles.
- R7: In word mode (BYTE_MODE=0) one read of ACCESS_CYC cycles returns all 16 result bits.
- R8: Each finished read produces exactly one `res_valid_o` pulse, one cycle wide, with `res_data_o` equal to the value the converter held for that conversion.
- R9: If ready has not completed its fall-and-rise within TIMEOUT_CYC cycles after the convert pulse ends, `timeout_o` pulses for one cycle exactly TIMEOUT_CYC cycles after the pulse end. No result is produced and both control lines are high.
- R10: While `auto_en_i` is high, conversions are requested every TIMER_CYC cycles, so consecutive convert pulses start exactly TIMER_CYC cycles apart.
- R11: A start received during a conversion is held, and its convert pulse starts exactly SPACING_CYC+SETUP_CYC cycles after the previous pulse started. Several starts received during one conversion merge into a single further conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle conversion request |
| auto_en_i | input | 1 | Enables periodic requests every TIMER_CYC cycles |
| adc_ready_i | input | 1 | Converter ready: low while a conversion runs |
| adc_data_i | input | BYTE_MODE ? 8 : 16 | Converter parallel data bus |
| adc_sel_n_o | output | 1 | Converter chip select, active low |
| adc_conv_n_o | output | 1 | Low = convert, high = read |
| adc_lo_byte_o | output | 1 | Byte select: 0 = bits 15:8, 1 = bits 7:0 |
| res_valid_o | output | 1 | One-cycle strobe for a new result |
| res_data_o | output | 16 | Assembled result |
| timeout_o | output | 1 | One-cycle strobe when ready failed to return |

## Verification
The pulse timing is measured on the falling clock edge by counting the cycles the control lines stay low. The setup phase must last SETUP_CYC cycles and the convert phase PULSE_CYC cycles. Start-to-start distances are taken between the first sampled cycles of consecutive pulses, so a held request must show SPACING_CYC+SETUP_CYC and timer-driven requests must show TIMER_CYC. The timeout strobe is expected exactly TIMEOUT_CYC cycles after the last cycle of the pulse. The converter model drives garbage until the bus has been enabled and the byte select has been stable for four cycles, so any read sampled before ACCESS_CYC cycles shows up as a wrong result in the cycle its valid strobe appears.

// File: rtl/adc_read_seq.sv
module adc_read_seq #(
  parameter bit BYTE_MODE   = 1'b1,
  parameter int SETUP_CYC   = 1,
  parameter int PULSE_CYC   = 4,
  parameter int SPACING_CYC = 500,
  parameter int ACCESS_CYC  = 5,
  parameter int RELEASE_CYC = 5,
  parameter int TIMEOUT_CYC = 600,
  parameter int TIMER_CYC   = 800,
  localparam int BUS_W      = BYTE_MODE ? 8 : 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             auto_en_i,
  input  logic             adc_ready_i,
  input  logic [BUS_W-1:0] adc_data_i,
  output logic             adc_sel_n_o,
  output logic             adc_conv_n_o,
  output logic             adc_lo_byte_o,
  output logic             res_valid_o,
  output logic [15:0]      res_data_o,
  output logic             timeout_o
);
  localparam int M1    = SETUP_CYC > PULSE_CYC ? SETUP_CYC : PULSE_CYC;
  localparam int M2    = ACCESS_CYC > RELEASE_CYC ? ACCESS_CYC : RELEASE_CYC;
  localparam int CW    = $clog2((M1 > M2 ? M1 : M2) + 1);
  localparam int SPC_W = $clog2(SPACING_CYC + 1);
  localparam int TMO_W = $clog2(TIMEOUT_CYC + 1);
  localparam int TMR_W = $clog2(TIMER_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_PULSE, S_WLO, S_WHI, S_READ, S_REL} st_t;

  st_t              state;
  logic [CW-1:0]    cnt;
  logic [SPC_W-1:0] spc;
  logic [TMO_W-1:0] tmo;
  logic [TMR_W-1:0] tmr;
  logic [7:0]       hi_q;
  logic             byte_q, pend, rdy_s1, rdy_s;
  logic [15:0]      word_w;

  wire go   = (state == S_IDLE) && pend && (spc == '0);
  wire tick = auto_en_i && (tmr == TMR_W'(TIMER_CYC - 1));

  assign adc_sel_n_o   = !(state == S_PULSE || state == S_READ);
  assign adc_conv_n_o  = !(state == S_SETUP || state == S_PULSE);
  assign adc_lo_byte_o = byte_q;

  generate
    if (BYTE_MODE) begin : g_byte
      assign word_w = {hi_q, adc_data_i};
    end else begin : g_word
      assign word_w = adc_data_i;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rdy_s1 <= 1'b1;
      rdy_s  <= 1'b1;
      pend   <= 1'b0;
      tmr    <= '0;
    end else begin
      rdy_s1 <= adc_ready_i;
      rdy_s  <= rdy_s1;
      pend   <= (pend && !go) || start_i || tick;
      if (!auto_en_i || tick) tmr <= '0;
      else                    tmr <= tmr + TMR_W'(1);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state       <= S_IDLE;
      cnt         <= '0;
      spc         <= '0;
      tmo         <= '0;
      hi_q        <= '0;
      byte_q      <= 1'b0;
      res_valid_o <= 1'b0;
      res_data_o  <= '0;
      timeout_o   <= 1'b0;
    end else begin
      res_valid_o <= 1'b0;
      timeout_o   <= 1'b0;
      if (spc != '0) spc <= spc - SPC_W'(1);
      case (state)
        S_IDLE: if (go) begin
          state <= S_SETUP;
          cnt   <= CW'(SETUP_CYC - 1);
        end
        S_SETUP: if (cnt == '0) begin
          state <= S_PULSE;
          cnt   <= CW'(PULSE_CYC - 1);
          spc   <= SPC_W'(SPACING_CYC - 1);
        end else cnt <= cnt - CW'(1);
        S_PULSE: if (cnt == '0) begin
          state <= S_WLO;
          tmo   <= '0;
        end else cnt <= cnt - CW'(1);
        S_WLO, S_WHI: if (tmo == TMO_W'(TIMEOUT_CYC - 1)) begin
          timeout_o <= 1'b1;
          state     <= S_IDLE;
        end else begin
          tmo <= tmo + TMO_W'(1);
          if (state == S_WLO && !rdy_s) state <= S_WHI;
          if (state == S_WHI && rdy_s) begin
            state  <= S_READ;
            cnt    <= CW'(ACCESS_CYC - 1);
            byte_q <= 1'b0;
          end
        end
        S_READ: if (cnt != '0) cnt <= cnt - CW'(1);
        else if (BYTE_MODE && !byte_q) begin
          hi_q   <= adc_data_i[7:0];
          byte_q <= 1'b1;
          cnt    <= CW'(ACCESS_CYC - 1);
        end else begin
          res_data_o  <= word_w;
          res_valid_o <= 1'b1;
          byte_q      <= 1'b0;
          state       <= S_REL;
          cnt         <= CW'(RELEASE_CYC - 1);
        end
        S_REL: if (cnt == '0) state <= S_IDLE;
               else cnt <= cnt - CW'(1);
        default: state <= S_IDLE;
      endcase
    end
endmodule

// File: rtl/adc_read_seq_chk.sv
module adc_read_seq_chk #(
  parameter int PULSE_CYC   = 4,
  parameter int SPACING_CYC = 500
) (
  input logic clk,
  input logic rst_n,
  input logic sel_n,
  input logic conv_n,
  input logic ready,
  input logic valid,
  input logic timeout
);
  localparam int GW = $clog2(SPACING_CYC + 1) + 1;
  localparam int PW = $clog2(PULSE_CYC + 2) + 1;

  wire trig = !sel_n && !conv_n;
  logic          trig_d;
  logic [PW-1:0] plen;
  logic [GW-1:0] gap;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      trig_d <= 1'b0;
      plen   <= '0;
      gap    <= GW'(SPACING_CYC);
    end else begin
      trig_d <= trig;
      if (!trig)         plen <= '0;
      else if (plen != '1) plen <= plen + PW'(1);
      if (trig && !trig_d)              gap <= GW'(1);
      else if (gap < GW'(SPACING_CYC))  gap <= gap + GW'(1);
    end

  a_r2_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_d && !trig) |-> (plen == PW'(PULSE_CYC)));
  a_r4_min_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !trig_d) |-> (gap >= GW'(SPACING_CYC)));
  a_r5_no_read_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && conv_n) |-> ready);
  a_r5_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (sel_n || conv_n));
  a_r8_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);
  a_r9_timeout_idle: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> (!valid && sel_n && conv_n));
endmodule

bind adc_read_seq adc_read_seq_chk #(.PULSE_CYC(PULSE_CYC), .SPACING_CYC(SPACING_CYC)) chk_i (
  .clk(clk), .rst_n(rst_n), .sel_n(adc_sel_n_o), .conv_n(adc_conv_n_o),
  .ready(adc_ready_i), .valid(res_valid_o), .timeout(timeout_o));

// File: tb/adc_read_seq_tb_top.sv
module adc_conv_model #(
  parameter int BUS_W    = 8,
  parameter int CONV_CYC = 400,
  parameter int ACC_M    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_n,
  input  logic             conv_n,
  input  logic             lo_byte,
  input  logic             hang,
  input  logic [15:0]      ain,
  output logic             ready,
  output logic [BUS_W-1:0] dout,
  output logic [15:0]      last_word,
  output int               n_trig,
  output int               n_bad_read,
  output int               n_retrig
);
  logic [15:0] held;
  int cnt, acc;
  logic trig_d, byte_d;
  wire trig = !sel_n && !conv_n;
  wire en   = !sel_n && conv_n;
  wire [15:0] sel_w = lo_byte ? {8'h00, last_word[7:0]}
                    : (BUS_W == 8 ? {8'h00, last_word[15:8]} : last_word);
  wire [15:0] junk = 16'h5AA5;
  assign dout = (en && lo_byte == byte_d && acc >= ACC_M) ? sel_w[BUS_W-1:0] : junk[BUS_W-1:0];

  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ready <= 1'b1; held <= '0; last_word <= '0; cnt <= 0; acc <= 0;
      trig_d <= 1'b0; byte_d <= 1'b0; n_trig <= 0; n_bad_read <= 0; n_retrig <= 0;
    end else begin
      trig_d <= trig;
      byte_d <= lo_byte;
      acc    <= en ? ((lo_byte != byte_d) ? 1 : acc + 1) : 0;
      if (en && !ready) n_bad_read <= n_bad_read + 1;
      if (trig && !trig_d && ready) begin
        ready <= 1'b0; held <= ain; cnt <= CONV_CYC; n_trig <= n_trig + 1;
      end else if (!ready && !hang) begin
        if (cnt > 1) cnt <= cnt - 1;
        else begin
          ready <= 1'b1; last_word <= held;
          if (trig) n_retrig <= n_retrig + 1;
        end
      end
    end
endmodule

module adc_read_seq_tb_top;
  localparam int SETUP_CYC = 1, PULSE_CYC = 4, SPACING_CYC = 500, ACCESS_CYC = 5;
  localparam int RELEASE_CYC = 5, TIMEOUT_CYC = 600, TIMER_CYC = 800;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, auto_en = 1'b0, hang = 1'b0;
  logic [15:0] ain = '0;
  always #10 clk = !clk;
  always @(posedge clk) ain <= 16'($urandom());

  logic rdy_b, sel_b, conv_b, lo_b, v_b, to_b;
  logic [7:0]  bus_b;
  logic [15:0] res_b, lw_b;
  int nt_b, nbr_b, nrt_b;
  logic rdy_w, sel_w, conv_w, lo_w, v_w, to_w;
  logic [15:0] bus_w, res_w, lw_w;
  int nt_w, nbr_w, nrt_w;

  adc_read_seq #(.BYTE_MODE(1'b1), .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC),
    .SPACING_CYC(SPACING_CYC), .ACCESS_CYC(ACCESS_CYC), .RELEASE_CYC(RELEASE_CYC),
    .TIMEOUT_CYC(TIMEOUT_CYC), .TIMER_CYC(TIMER_CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .auto_en_i(auto_en), .adc_ready_i(rdy_b),
    .adc_data_i(bus_b), .adc_sel_n_o(sel_b), .adc_conv_n_o(conv_b), .adc_lo_byte_o(lo_b),
    .res_valid_o(v_b), .res_data_o(res_b), .timeout_o(to_b));
  adc_conv_model #(.BUS_W(8)) mdl_b (.clk(clk), .rst_n(rst_n), .sel_n(sel_b), .conv_n(conv_b),
    .lo_byte(lo_b), .hang(hang), .ain(ain), .ready(rdy_b), .dout(bus_b), .last_word(lw_b),
    .n_trig(nt_b), .n_bad_read(nbr_b), .n_retrig(nrt_b));

  adc_read_seq #(.BYTE_MODE(1'b0), .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC),
    .SPACING_CYC(SPACING_CYC), .ACCESS_CYC(ACCESS_CYC), .RELEASE_CYC(RELEASE_CYC),
    .TIMEOUT_CYC(TIMEOUT_CYC), .TIMER_CYC(TIMER_CYC)) dut_w_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .auto_en_i(auto_en), .adc_ready_i(rdy_w),
    .adc_data_i(bus_w), .adc_sel_n_o(sel_w), .adc_conv_n_o(conv_w), .adc_lo_byte_o(lo_w),
    .res_valid_o(v_w), .res_data_o(res_w), .timeout_o(to_w));
  adc_conv_model #(.BUS_W(16)) mdl_w (.clk(clk), .rst_n(rst_n), .sel_n(sel_w), .conv_n(conv_w),
    .lo_byte(lo_w), .hang(hang), .ain(ain), .ready(rdy_w), .dout(bus_w), .last_word(lw_w),
    .n_trig(nt_w), .n_bad_read(nbr_w), .n_retrig(nrt_w));

  int n_chk = 0, n_err = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  int cyc = 0, n_starts = 0, last_start = 0, last_iv = 0, pend_end = 0;
  int plen = 0, slen = 0, n_res_b = 0, n_res_w = 0, n_to = 0, to_iv = 0;
  bit trig_q = 0, vb_q = 0, vw_q = 0;

  always @(negedge clk) if (rst_n) begin
    bit trig;
    cyc++;
    trig = !sel_b && !conv_b;
    if (trig && !trig_q) begin
      chk(slen == SETUP_CYC, "R3 setup", slen, SETUP_CYC);
      if (n_starts > 0) begin
        last_iv = cyc - last_start;
        chk(last_iv >= SPACING_CYC, "R4 spacing", last_iv, SPACING_CYC);
      end
      last_start = cyc;
      n_starts++;
      plen = 0;
    end
    if (trig) plen++;
    if (!trig && trig_q) begin
      chk(plen == PULSE_CYC, "R2 pulse", plen, PULSE_CYC);
      pend_end = cyc - 1;
    end
    if (conv_b) slen = 0; else if (sel_b) slen++;
    if (v_b) begin
      n_res_b++;
      chk(res_b == lw_b, "R6 byte result", int'(res_b), int'(lw_b));
      chk(!vb_q, "R8 valid width", 1, 0);
    end
    if (v_w) begin
      n_res_w++;
      chk(res_w == lw_w, "R7 word result", int'(res_w), int'(lw_w));
      chk(!vw_q, "R8 valid width word", 1, 0);
    end
    if (to_b) begin
      n_to++;
      to_iv = cyc - 1 - pend_end;
    end
    trig_q = trig;
    vb_q = v_b;
    vw_q = v_w;
  end

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_res(input int n);
    int lim = 0;
    while (n_res_b < n && lim < 5000) begin @(negedge clk); lim++; end
  endtask

  task automatic wait_starts(input int n);
    int lim = 0;
    while (n_starts < n && lim < 5000) begin @(negedge clk); lim++; end
  endtask

  initial begin
    int base, rb;
    void'($urandom(32'd2024));
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(sel_b && conv_b, "R1 reset lines", {sel_b, conv_b}, 3);
    chk(!lo_b && !v_b && !to_b, "R1 reset flags", {lo_b, v_b, to_b}, 0);
    rst_n = 1'b1;

    pulse_start();
    wait_res(1);
    chk(n_res_b == 1, "R8 first result", n_res_b, 1);
    repeat (200) @(negedge clk);

    // R11: held request served at first allowed cycle
    base = n_starts;
    pulse_start();
    repeat (60) @(negedge clk);
    pulse_start();
    wait_starts(base + 2);
    chk(last_iv == SPACING_CYC + SETUP_CYC, "R11 held start", last_iv, SPACING_CYC + SETUP_CYC);
    repeat (700) @(negedge clk);

    // R11: several starts during one conversion merge into one
    base = n_starts;
    pulse_start();
    repeat (30) @(negedge clk);
    pulse_start();
    repeat (20) @(negedge clk);
    pulse_start();
    pulse_start();
    repeat (1800) @(negedge clk);
    chk(n_starts == base + 2, "R11 merge", n_starts - base, 2);

    // R10: periodic requests
    auto_en = 1'b1;
    base = n_starts;
    wait_starts(base + 1);
    for (int k = 0; k < 3; k++) begin
      wait_starts(base + 2 + k);
      chk(last_iv == TIMER_CYC, "R10 timer interval", last_iv, TIMER_CYC);
    end
    @(negedge clk) auto_en = 1'b0;
    repeat (900) @(negedge clk);

    // R9: ready never returns
    hang = 1'b1;
    base = n_to;
    rb = n_res_b;
    pulse_start();
    repeat (TIMEOUT_CYC + 100) @(negedge clk);
    chk(n_to == base + 1, "R9 timeout seen", n_to - base, 1);
    chk(to_iv == TIMEOUT_CYC, "R9 timeout cycle", to_iv, TIMEOUT_CYC);
    chk(n_res_b == rb, "R9 no result", n_res_b - rb, 0);
    chk(sel_b && conv_b, "R9 idle lines", {sel_b, conv_b}, 3);
    hang = 1'b0;
    repeat (600) @(negedge clk);
    rb = n_res_b;
    pulse_start();
    wait_res(rb + 1);
    chk(n_res_b == rb + 1, "R9 recovery", n_res_b - rb, 1);

    // random traffic
    for (int i = 0; i < 20; i++) begin
      repeat ($urandom_range(0, 1200)) @(negedge clk);
      pulse_start();
    end
    repeat (2000) @(negedge clk);

    chk(nbr_b == 0 && nbr_w == 0, "R5 read while busy", nbr_b + nbr_w, 0);
    chk(nrt_b == 0 && nrt_w == 0, "R5 retrigger", nrt_b + nrt_w, 0);
    chk(n_res_b == nt_b - 1, "R8 byte result count", n_res_b, nt_b - 1);
    chk(n_res_w == nt_w - 1, "R8 word result count", n_res_w, nt_w - 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule